// File: doc/BRIEF.md
# Interrupt acceptance and entry sequencer

This block sits beside an instruction fetch unit and decides, at each instruction boundary, whether a pending interrupt may be taken. Every fetched instruction arrives with a strobe, a two-bit class and the return address that the handler would later resume at. Non-maskable requests are captured on a rising edge and held until they are serviced. A maskable request is a level, and it is gated by the interrupt-enable flag. The two stack-pointer-load instructions must run back to back as a pair, and no interrupt of any kind may be taken between them. An extension prefix binds to the instruction after it, so sampling waits one further instruction after the prefix.

Once a request is taken, the block holds the fetch unit off through a fixed hardware entry sequence. The sequence is one dummy fetch, then a push of the return PC onto the second stack, then a push of the flags onto the first stack, then a vector load into the PC. In that last cycle the block also writes back both decremented stack pointers and requests that the enable flag be cleared. An acknowledge line that identifies the interrupt kind stays high for the whole sequence.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, busy, dummy_fetch, wr_en, pc_load, ie_clear, sp_wb, nmi_ack and irq_ack are all low and nothing is pending.
- R2: A fetch of class 1 or 2 (stack-pointer loads) while no pair is open opens a pair. No interrupt, NMI included, is taken at that fetch or at any later fetch until the other class of the pair is fetched.
- R3: The fetch that closes a pair (the class of 1 or 2 not yet seen) is not a sampling point. The fetch after it is a sampling point.
- R4: A fetch of class 3 (extension prefix) is not a sampling point. The next fetch of class 0 is.
- R5: A rising edge on nmi_in is latched even while sampling is blocked. It is taken at the next open boundary and serviced exactly once.
- R6: A maskable request is taken only at a class 0 boundary where irq_req and ie_flag are both high.
- R7: When an NMI and a maskable request are both pending at one boundary, the NMI is taken with vector 0x0100. The maskable request remains pending and is taken at a later boundary.
- R8: The cycle after an accepting fetch shows dummy_fetch. The next cycle writes the return PC at address sp2_in-1 (wrapping modulo the stack width). The next writes the zero-extended flags at sp1_in-1. The next asserts pc_load with the vector (0x0100 for NMI, irq_vector otherwise), ie_clear, and sp_wb with sp1_in-1 and sp2_in-1. busy is high for exactly these four cycles.
- R9: nmi_ack or irq_ack, matching the accepted kind, is high for all four entry cycles. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | One-cycle strobe per fetched instruction |
| fetch_class | input | 2 | 0 plain, 1 first-stack load, 2 second-stack load, 3 extension prefix |
| fetch_pc | input | PCW | Return address belonging to this boundary |
| flags_in | input | FW | Current flag register |
| ie_flag | input | 1 | Interrupt-enable flag |
| sp1_in | input | SPW | First stack pointer (flags stack) |
| sp2_in | input | SPW | Second stack pointer (PC stack) |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| irq_req | input | 1 | Maskable request, level |
| irq_vector | input | PCW | Handler address for the maskable request |
| busy | output | 1 | Entry sequence in progress, fetch must stall |
| dummy_fetch | output | 1 | Dummy fetch bus cycle request |
| wr_en | output | 1 | Stack write request |
| wr_addr | output | SPW | Stack write address |
| wr_data | output | PCW | Stack write data |
| pc_load | output | 1 | Load PC with pc_vector |
| pc_vector | output | PCW | Handler entry address |
| nmi_ack | output | 1 | NMI entry in progress |
| irq_ack | output | 1 | Maskable entry in progress |
| ie_clear | output | 1 | Clear the interrupt-enable flag |
| sp_wb | output | 1 | Write back decremented stack pointers |
| sp1_new | output | SPW | Decremented first stack pointer |
| sp2_new | output | SPW | Decremented second stack pointer |

## Verification
The checker assumes that the fetch unit raises fetch_valid only while busy is low, and that each strobe lasts a single cycle. It also assumes that stack pointers and flags stay steady while an accepting fetch is sampled. The stimulus keeps to this: it issues each fetch for one cycle, waits out the full four-cycle entry before the next fetch, and changes the stack pointers and flags only between fetches. Every NMI pulse is given one clock to be latched before the fetch that is meant to sample it, and the maskable request is dropped before the next fetch once its entry has been seen.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [1:0] {
    CLS_PLAIN  = 2'd0,
    CLS_SPLD_A = 2'd1,
    CLS_SPLD_B = 2'd2,
    CLS_EXT    = 2'd3
  } fetch_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DUMMY   = 3'd1,
    ST_PUSH_PC = 3'd2,
    ST_PUSH_FL = 3'd3,
    ST_VECTOR  = 3'd4
  } entry_st_e;

  localparam logic [15:0] NMI_VECTOR = 16'h0100;

  // Stack slot below a pointer; caller truncates to its own width.
  function automatic logic [31:0] stack_slot(input logic [31:0] sp);
    return sp - 32'd1;
  endfunction

  function automatic logic is_sp_load(input fetch_cls_e c);
    return (c == CLS_SPLD_A) || (c == CLS_SPLD_B);
  endfunction

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take_nmi,
  output logic nmi_edge,
  output logic nmi_pend
);
  logic nmi_q;

  assign nmi_edge = nmi_in & ~nmi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_in;
      nmi_pend <= nmi_edge | (nmi_pend & ~take_nmi);
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_valid,
  input  logic [1:0] fetch_class,
  input  logic       busy,
  input  logic       nmi_pend,
  input  logic       irq_req,
  input  logic       ie_flag,
  output logic       pair_open,
  output logic       boundary_open,
  output logic       take_nmi,
  output logic       take_irq
);
  fetch_cls_e cls;
  fetch_cls_e first_q;
  logic       fetch_ok;

  assign cls      = fetch_cls_e'(fetch_class);
  assign fetch_ok = fetch_valid & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_open <= 1'b0;
      first_q   <= CLS_PLAIN;
    end else if (fetch_ok && is_sp_load(cls)) begin
      if (!pair_open) begin
        pair_open <= 1'b1;
        first_q   <= cls;
      end else if (cls != first_q) begin
        pair_open <= 1'b0;
      end
    end
  end

  // A boundary samples only after a plain instruction outside a pair.
  assign boundary_open = fetch_ok & ~pair_open & (cls == CLS_PLAIN);
  assign take_nmi      = boundary_open & nmi_pend;
  assign take_irq      = boundary_open & ~nmi_pend & irq_req & ie_flag;
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
#(
  parameter int PCW = 16,
  parameter int FW  = 4,
  parameter int SPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take_nmi,
  input  logic           take_irq,
  input  logic [PCW-1:0] ret_pc,
  input  logic [FW-1:0]  flags_in,
  input  logic [SPW-1:0] sp1_in,
  input  logic [SPW-1:0] sp2_in,
  input  logic [PCW-1:0] irq_vector,
  output logic           busy,
  output logic           dummy_fetch,
  output logic           wr_en,
  output logic [SPW-1:0] wr_addr,
  output logic [PCW-1:0] wr_data,
  output logic           pc_load,
  output logic [PCW-1:0] pc_vector,
  output logic           nmi_ack,
  output logic           irq_ack,
  output logic           ie_clear,
  output logic           sp_wb,
  output logic [SPW-1:0] sp1_new,
  output logic [SPW-1:0] sp2_new
);
  localparam int PADW = PCW - FW;

  entry_st_e      st_q;
  logic           nmi_q;
  logic [PCW-1:0] pc_q;
  logic [FW-1:0]  fl_q;
  logic [SPW-1:0] sp1_q;
  logic [SPW-1:0] sp2_q;
  logic [PCW-1:0] vec_q;
  logic [SPW-1:0] slot1;
  logic [SPW-1:0] slot2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      nmi_q <= 1'b0;
      pc_q  <= '0;
      fl_q  <= '0;
      sp1_q <= '0;
      sp2_q <= '0;
      vec_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (take_nmi || take_irq) begin
          st_q  <= ST_DUMMY;
          nmi_q <= take_nmi;
          pc_q  <= ret_pc;
          fl_q  <= flags_in;
          sp1_q <= sp1_in;
          sp2_q <= sp2_in;
          vec_q <= take_nmi ? PCW'(NMI_VECTOR) : irq_vector;
        end
        ST_DUMMY:   st_q <= ST_PUSH_PC;
        ST_PUSH_PC: st_q <= ST_PUSH_FL;
        ST_PUSH_FL: st_q <= ST_VECTOR;
        ST_VECTOR:  st_q <= ST_IDLE;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  assign slot1 = SPW'(stack_slot(32'(sp1_q)));
  assign slot2 = SPW'(stack_slot(32'(sp2_q)));

  always_comb begin
    busy        = (st_q != ST_IDLE);
    dummy_fetch = (st_q == ST_DUMMY);
    wr_en       = 1'b0;
    wr_addr     = '0;
    wr_data     = '0;
    pc_load     = 1'b0;
    pc_vector   = '0;
    ie_clear    = 1'b0;
    sp_wb       = 1'b0;
    sp1_new     = '0;
    sp2_new     = '0;
    unique case (st_q)
      ST_PUSH_PC: begin
        wr_en   = 1'b1;
        wr_addr = slot2;
        wr_data = pc_q;
      end
      ST_PUSH_FL: begin
        wr_en   = 1'b1;
        wr_addr = slot1;
        wr_data = {{PADW{1'b0}}, fl_q};
      end
      ST_VECTOR: begin
        pc_load   = 1'b1;
        pc_vector = vec_q;
        ie_clear  = 1'b1;
        sp_wb     = 1'b1;
        sp1_new   = slot1;
        sp2_new   = slot2;
      end
      default: ;
    endcase
    nmi_ack = busy & nmi_q;
    irq_ack = busy & ~nmi_q;
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int PCW = 16,
  parameter int FW  = 4,
  parameter int SPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fetch_valid,
  input  logic [1:0]     fetch_class,
  input  logic [PCW-1:0] fetch_pc,
  input  logic [FW-1:0]  flags_in,
  input  logic           ie_flag,
  input  logic [SPW-1:0] sp1_in,
  input  logic [SPW-1:0] sp2_in,
  input  logic           nmi_in,
  input  logic           irq_req,
  input  logic [PCW-1:0] irq_vector,
  output logic           busy,
  output logic           dummy_fetch,
  output logic           wr_en,
  output logic [SPW-1:0] wr_addr,
  output logic [PCW-1:0] wr_data,
  output logic           pc_load,
  output logic [PCW-1:0] pc_vector,
  output logic           nmi_ack,
  output logic           irq_ack,
  output logic           ie_clear,
  output logic           sp_wb,
  output logic [SPW-1:0] sp1_new,
  output logic [SPW-1:0] sp2_new
);
  // Internal events, named for the checker.
  logic nmi_edge;
  logic nmi_pend;
  logic pair_open;
  logic boundary_open;
  logic take_nmi;
  logic take_irq;

  irq_nmi_latch u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_in   (nmi_in),
    .take_nmi (take_nmi),
    .nmi_edge (nmi_edge),
    .nmi_pend (nmi_pend)
  );

  irq_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid   (fetch_valid),
    .fetch_class   (fetch_class),
    .busy          (busy),
    .nmi_pend      (nmi_pend),
    .irq_req       (irq_req),
    .ie_flag       (ie_flag),
    .pair_open     (pair_open),
    .boundary_open (boundary_open),
    .take_nmi      (take_nmi),
    .take_irq      (take_irq)
  );

  irq_entry_fsm #(.PCW(PCW), .FW(FW), .SPW(SPW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_nmi    (take_nmi),
    .take_irq    (take_irq),
    .ret_pc      (fetch_pc),
    .flags_in    (flags_in),
    .sp1_in      (sp1_in),
    .sp2_in      (sp2_in),
    .irq_vector  (irq_vector),
    .busy        (busy),
    .dummy_fetch (dummy_fetch),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .pc_load     (pc_load),
    .pc_vector   (pc_vector),
    .nmi_ack     (nmi_ack),
    .irq_ack     (irq_ack),
    .ie_clear    (ie_clear),
    .sp_wb       (sp_wb),
    .sp1_new     (sp1_new),
    .sp2_new     (sp2_new)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int PCW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fetch_valid,
  input logic [1:0]     fetch_class,
  input logic           ie_flag,
  input logic           busy,
  input logic           dummy_fetch,
  input logic           wr_en,
  input logic           pc_load,
  input logic [PCW-1:0] pc_vector,
  input logic           nmi_ack,
  input logic           irq_ack,
  input logic           nmi_edge,
  input logic           nmi_pend,
  input logic           pair_open,
  input logic           take_irq
);
  // Input assumption: no fetch while the entry sequence runs (R8).
  a_r8_no_fetch_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fetch_valid);

  a_r8_dummy_then_push: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_fetch |=> (wr_en && !dummy_fetch));

  a_r8_push_then_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |=> pc_load);

  a_r9_ack_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_ack && irq_ack));

  a_r9_ack_covers_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot0({nmi_ack, irq_ack}) && (nmi_ack || irq_ack));

  a_r2_pair_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_open && fetch_valid) |=> !dummy_fetch);

  a_r4_ext_defers: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_class == 2'd3) |=> !dummy_fetch);

  a_r5_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_edge |=> nmi_pend);

  a_r6_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> ie_flag);

  a_r7_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> !nmi_pend);

  a_r7_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && nmi_ack) |-> pc_vector == PCW'(16'h0100));
endmodule

bind irq_entry_seq irq_entry_chk #(.PCW(PCW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .fetch_class (fetch_class),
  .ie_flag     (ie_flag),
  .busy        (busy),
  .dummy_fetch (dummy_fetch),
  .wr_en       (wr_en),
  .pc_load     (pc_load),
  .pc_vector   (pc_vector),
  .nmi_ack     (nmi_ack),
  .irq_ack     (irq_ack),
  .nmi_edge    (nmi_edge),
  .nmi_pend    (nmi_pend),
  .pair_open   (pair_open),
  .take_irq    (take_irq)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [1:0]  fetch_class = 2'd0;
  logic [15:0] fetch_pc = '0;
  logic [3:0]  flags_in = '0;
  logic        ie_flag = 1'b0;
  logic [7:0]  sp1_in = 8'h40;
  logic [7:0]  sp2_in = 8'h80;
  logic        nmi_in = 1'b0;
  logic        irq_req = 1'b0;
  logic [15:0] irq_vector = 16'h0200;
  logic        busy, dummy_fetch, wr_en, pc_load, nmi_ack, irq_ack;
  logic        ie_clear, sp_wb;
  logic [7:0]  wr_addr, sp1_new, sp2_new;
  logic [15:0] wr_data, pc_vector;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic        nmi;
    logic [15:0] pc;
    logic [3:0]  fl;
    logic [7:0]  s1;
    logic [7:0]  s2;
    logic [15:0] vec;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_class(fetch_class),
    .fetch_pc(fetch_pc), .flags_in(flags_in), .ie_flag(ie_flag), .sp1_in(sp1_in),
    .sp2_in(sp2_in), .nmi_in(nmi_in), .irq_req(irq_req), .irq_vector(irq_vector),
    .busy(busy), .dummy_fetch(dummy_fetch), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pc_load(pc_load), .pc_vector(pc_vector), .nmi_ack(nmi_ack),
    .irq_ack(irq_ack), .ie_clear(ie_clear), .sp_wb(sp_wb), .sp1_new(sp1_new),
    .sp2_new(sp2_new)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] below(input logic [7:0] sp);
    return (sp == 8'h00) ? 8'hFF : sp - 8'h01;
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Driver: one fetch; pushes the expected entry when it should be taken.
  task automatic fetch(input string req, input logic [1:0] cls, input logic [15:0] pc,
                       input logic take, input logic as_nmi);
    exp_t e;
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_class = cls;
    fetch_pc    = pc;
    if (take) begin
      e.nmi = as_nmi; e.pc = pc; e.fl = flags_in; e.s1 = sp1_in; e.s2 = sp2_in;
      e.vec = as_nmi ? 16'h0100 : irq_vector;
      exp_q.push_back(e);
    end
    @(negedge clk);
    fetch_valid = 1'b0;
    chk(req, {31'd0, dummy_fetch}, {31'd0, take});
    if (take) repeat (3) @(negedge clk);
  endtask

  task automatic pulse_nmi();
    @(negedge clk); nmi_in = 1'b1;
    @(negedge clk); nmi_in = 1'b0;
  endtask

  // Monitor: pops one expected entry per observed sequence.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && dummy_fetch) begin
        if (exp_q.size() == 0) begin
          chk("R2 unexpected entry", 32'd1, 32'd0);
        end else begin
          e = exp_q.pop_front();
          chk("R9 nmi_ack dummy", {31'd0, nmi_ack}, {31'd0, e.nmi});
          chk("R9 irq_ack dummy", {31'd0, irq_ack}, {31'd0, ~e.nmi});
          @(negedge clk);
          chk("R8 pc push en", {31'd0, wr_en}, 32'd1);
          chk("R8 pc push addr", {24'd0, wr_addr}, {24'd0, below(e.s2)});
          chk("R8 pc push data", {16'd0, wr_data}, {16'd0, e.pc});
          chk("R9 ack pc push", {30'd0, nmi_ack, irq_ack}, {30'd0, e.nmi, ~e.nmi});
          @(negedge clk);
          chk("R8 flag push en", {31'd0, wr_en}, 32'd1);
          chk("R8 flag push addr", {24'd0, wr_addr}, {24'd0, below(e.s1)});
          chk("R8 flag push data", {16'd0, wr_data}, {28'd0, e.fl});
          @(negedge clk);
          chk("R8 vector load", {31'd0, pc_load}, 32'd1);
          chk("R7 R8 vector", {16'd0, pc_vector}, {16'd0, e.vec});
          chk("R8 ie clear", {30'd0, ie_clear, sp_wb}, 32'd3);
          chk("R8 sp writeback", {16'd0, sp1_new, sp2_new}, {16'd0, below(e.s1), below(e.s2)});
          chk("R9 ack vector", {30'd0, nmi_ack, irq_ack}, {30'd0, e.nmi, ~e.nmi});
          @(negedge clk);
          chk("R8 busy drop", {31'd0, busy}, 32'd0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {24'd0, busy, dummy_fetch, wr_en, pc_load, ie_clear, sp_wb, nmi_ack, irq_ack}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    fetch("R1 nothing pending", 2'd0, 16'h1000, 1'b0, 1'b0);

    // R6: enable gates the maskable request
    flags_in = 4'hA; irq_req = 1'b1; ie_flag = 1'b0;
    fetch("R6 disabled", 2'd0, 16'h1001, 1'b0, 1'b0);
    ie_flag = 1'b1;
    fetch("R6 enabled", 2'd0, 16'h1002, 1'b1, 1'b0);
    irq_req = 1'b0; ie_flag = 1'b0;

    // R2/R3/R5: NMI arrives, pair opened by class 1
    pulse_nmi();
    fetch("R2 pair opens", 2'd1, 16'h2000, 1'b0, 1'b0);
    fetch("R2 inside pair", 2'd0, 16'h2001, 1'b0, 1'b0);
    fetch("R2 same class again", 2'd1, 16'h2002, 1'b0, 1'b0);
    fetch("R3 pair closes", 2'd2, 16'h2003, 1'b0, 1'b0);
    fetch("R3 R5 taken after pair", 2'd0, 16'h2004, 1'b1, 1'b1);
    fetch("R5 serviced once", 2'd0, 16'h2005, 1'b0, 1'b0);

    // R4: extension prefix defers
    irq_req = 1'b1; ie_flag = 1'b1; flags_in = 4'h5; irq_vector = 16'h0340;
    fetch("R4 prefix", 2'd3, 16'h3000, 1'b0, 1'b0);
    fetch("R4 after prefix", 2'd0, 16'h3001, 1'b1, 1'b0);
    irq_req = 1'b0; ie_flag = 1'b0;

    // R7: both pending, NMI first
    pulse_nmi();
    irq_req = 1'b1; ie_flag = 1'b1;
    fetch("R7 nmi wins", 2'd0, 16'h4000, 1'b1, 1'b1);
    fetch("R7 irq later", 2'd0, 16'h4001, 1'b1, 1'b0);
    irq_req = 1'b0; ie_flag = 1'b0;

    // R8 wrap with reversed pair order, R5 pulse inside pair
    sp1_in = 8'h00; sp2_in = 8'h00; flags_in = 4'hF;
    fetch("R2 pair opens by class 2", 2'd2, 16'h5000, 1'b0, 1'b0);
    pulse_nmi();
    fetch("R2 nmi held in pair", 2'd0, 16'h5001, 1'b0, 1'b0);
    fetch("R3 close by class 1", 2'd1, 16'h5002, 1'b0, 1'b0);
    fetch("R5 R8 wrap entry", 2'd0, 16'h5003, 1'b1, 1'b1);

    repeat (4) @(negedge clk);
    chk("R8 all entries seen", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule